// File: doc/BRIEF.md
# Frame CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy check over the bytes of a command or response frame as they stream past on a byte interface. Every accepted byte is folded into a reflected (shift-right) CRC register in a single cycle. The update is an unrolled chain of eight single-bit steps, and each byte is consumed least-significant bit first, which matches the order in which the bits leave a serial link. The register is preset to all ones whenever a frame starts. The feedback constant is the reflected form of x^16 + x^15 + x^2 + 1.

In generate mode the block reports the CRC of the frame one cycle after the last byte, together with a one-cycle done strobe. The reported value is in normal order, and a transmitter appends its high byte first and its low byte second. In check mode the two received CRC bytes are streamed through the same register as the last two bytes of the frame. A zero residue then means the frame is intact. The result is flagged as pass or fail together with the done strobe.

Top module: `crc16_frame_engine`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `pass_o` and `fail_o` are low and `crc_o` is 0x0000.
- R2: The CRC covers every accepted byte, each taken bit 0 first. The register is preset to 0xFFFF and the divisor is x^16 + x^15 + x^2 + 1. For the frame 0x80, 0x00, 0x02, 0x0F, 0x0B the reported CRC is 0xC029.
- R3: `crc_o` is in normal order: the byte appended first on the wire is `crc_o[15:8]` and the second is `crc_o[7:0]` (0xC0 then 0x29 for the R2 frame).
- R4: `done_o` is high for exactly one cycle, in the cycle after each accepted byte that carries `in_eof_i`, and at no other time. `crc_o` is updated in that same cycle.
- R5: In check mode (`check_mode_i` = 1 at the end byte), a frame followed by its correct two CRC bytes gives `pass_o` = 1 and `fail_o` = 0 with `done_o`. `crc_o` then reads 0x0000.
- R6: In check mode, a frame whose data or CRC bytes are corrupted gives `fail_o` = 1 and `pass_o` = 0 with `done_o`. `pass_o` and `fail_o` are never high together and never high without `done_o`.
- R7: In generate mode (`check_mode_i` = 0 at the end byte), `pass_o` and `fail_o` stay low.
- R8: An accepted byte with `in_sof_i` in the middle of a frame discards the partial result and starts a new frame with that byte, with no done pulse for the discarded part.
- R9: Cycles with `in_valid_i` low are ignored whatever the data, start and end inputs are. A frame with idle gaps gives the same CRC as the same frame sent back to back.
- R10: `crc_o` holds its value between done pulses.
- R11: A single accepted byte carrying both `in_sof_i` and `in_eof_i` forms a one-byte frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| check_mode_i | input | 1 | 1 = check received CRC, 0 = generate CRC; sampled with the end byte |
| in_valid_i | input | 1 | Byte on `in_data_i` is accepted this cycle |
| in_sof_i | input | 1 | Accepted byte is the first of a frame |
| in_eof_i | input | 1 | Accepted byte is the last of a frame |
| in_data_i | input | 8 | Frame byte |
| crc_o | output | 16 | CRC in normal order (residue in check mode) |
| done_o | output | 1 | One-cycle strobe, result valid |
| pass_o | output | 1 | Check mode: residue zero |
| fail_o | output | 1 | Check mode: residue non-zero |

## Verification
The known five-byte frame pins down the bit order, the preset, the polynomial and the result byte order together. A change to any one of them moves the value away from 0xC029. Frames of all zeros and all ones show that the preset is applied, because a zero preset would map a leading run of zeros to zero. A set of pseudo-random frames of different lengths, sent with and without idle gaps carrying junk data, separates correct byte gating from updates on idle cycles. Check-mode frames with intact and flipped CRC bytes, a restart in the middle of a frame and a one-byte frame cover the residue test and the frame boundary handling.

// File: rtl/crc16_frame_pkg.sv
package crc16_frame_pkg;

  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  // One step of the reflected register: the incoming bit meets bit 0.
  function automatic crc_t crc_bit_step(input crc_t cur, input logic din, input crc_t poly);
    crc_t shifted;
    shifted = cur >> 1;
    crc_bit_step = (cur[0] ^ din) ? (shifted ^ poly) : shifted;
  endfunction

  // The reflected register keeps the first remainder byte in its low half.
  // Normal order puts that byte on top.
  function automatic crc_t to_normal_order(input crc_t reg_val);
    to_normal_order = {reg_val[7:0], reg_val[15:8]};
  endfunction

endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step
  import crc16_frame_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter crc_t POLY   = 16'hA001
) (
  input  crc_t              crc_in,
  input  logic [DATA_W-1:0] data_in,
  output crc_t              crc_out
);

  crc_t stage [DATA_W+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign stage[i+1] = crc_bit_step(stage[i], data_in[i], POLY);
  end

  assign crc_out = stage[DATA_W];

endmodule

// File: rtl/crc16_state_reg.sv
module crc16_state_reg
  import crc16_frame_pkg::*;
#(
  parameter crc_t INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  crc_t next_val,
  output crc_t cur_val
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_val <= INIT;
    end else if (take) begin
      cur_val <= next_val;
    end
  end

endmodule

// File: rtl/crc16_result_reg.sv
module crc16_result_reg
  import crc16_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic check_mode,
  input  logic residue_zero,
  input  crc_t final_val,
  output crc_t crc_o,
  output logic done_o,
  output logic pass_o,
  output logic fail_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_o  <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= frame_end;
      pass_o <= frame_end && check_mode && residue_zero;
      fail_o <= frame_end && check_mode && !residue_zero;
      if (frame_end) begin
        crc_o <= to_normal_order(final_val);
      end
    end
  end

endmodule

// File: rtl/crc16_frame_engine.sv
module crc16_frame_engine
  import crc16_frame_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter crc_t POLY   = 16'hA001,
  parameter crc_t INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_mode_i,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);

  // Named events, also observed by the checker.
  logic byte_take_w;
  logic frame_start_w;
  logic frame_end_w;
  logic residue_zero_w;

  crc_t cur_crc_w;
  crc_t base_crc_w;
  crc_t next_crc_w;

  assign byte_take_w    = in_valid_i;
  assign frame_start_w  = in_valid_i && in_sof_i;
  assign frame_end_w    = in_valid_i && in_eof_i;
  assign base_crc_w     = frame_start_w ? INIT : cur_crc_w;
  assign residue_zero_w = (next_crc_w == '0);

  crc16_byte_step #(
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) u_step (
    .crc_in  (base_crc_w),
    .data_in (in_data_i),
    .crc_out (next_crc_w)
  );

  crc16_state_reg #(
    .INIT (INIT)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (byte_take_w),
    .next_val (next_crc_w),
    .cur_val  (cur_crc_w)
  );

  crc16_result_reg u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end_w),
    .check_mode   (check_mode_i),
    .residue_zero (residue_zero_w),
    .final_val    (next_crc_w),
    .crc_o        (crc_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .fail_o       (fail_o)
  );

endmodule

// File: rtl/crc16_frame_engine_chk.sv
module crc16_frame_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        check_mode_i,
  input logic        frame_end_w,
  input logic        residue_zero_w,
  input logic [15:0] crc_o,
  input logic        done_o,
  input logic        pass_o,
  input logic        fail_o
);

  a_r4_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_w |=> done_o);

  a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> !done_o);

  a_r5_pass_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_w && check_mode_i && residue_zero_w) |=> (pass_o && crc_o == 16'h0000));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  a_r6_flag_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |-> done_o);

  a_r7_gen_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_w && !check_mode_i) |=> (!pass_o && !fail_o));

  a_r10_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> $stable(crc_o));

endmodule

bind crc16_frame_engine crc16_frame_engine_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .check_mode_i   (check_mode_i),
  .frame_end_w    (frame_end_w),
  .residue_zero_w (residue_zero_w),
  .crc_o          (crc_o),
  .done_o         (done_o),
  .pass_o         (pass_o),
  .fail_o         (fail_o)
);

// File: tb/crc16_frame_engine_tb.sv
module crc16_frame_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        check_mode_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_sof_i = 1'b0;
  logic        in_eof_i = 1'b0;
  logic [7:0]  in_data_i = 8'h00;
  logic [15:0] crc_o;
  logic        done_o, pass_o, fail_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] crc;
    logic        pass;
    logic        fail;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [7:0]  fb[$];
  logic [15:0] last_crc = 16'h0000;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  crc16_frame_engine u_dut (
    .clk(clk), .rst_n(rst_n), .check_mode_i(check_mode_i),
    .in_valid_i(in_valid_i), .in_sof_i(in_sof_i), .in_eof_i(in_eof_i),
    .in_data_i(in_data_i), .crc_o(crc_o), .done_o(done_o),
    .pass_o(pass_o), .fail_o(fail_o)
  );

  // Reference: long division, MSB-first shift of the bit stream, normal polynomial.
  function automatic logic [15:0] model_crc();
    logic [15:0] r;
    logic [15:0] rev;
    r = 16'hFFFF;
    foreach (fb[n]) begin
      for (int k = 0; k < 8; k++) begin
        logic top;
        top = r[15] ^ fb[n][k];
        r = {r[14:0], 1'b0};
        if (top) r = r ^ 16'h8005;
      end
    end
    for (int k = 0; k < 16; k++) rev[k] = r[15-k];
    return {rev[7:0], rev[15:8]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  // Driver: drives fb as one frame; gap idle cycles (with junk) between bytes.
  task automatic drive_bytes(input bit chk, input int gap, input bit with_eof);
    foreach (fb[n]) begin
      @(posedge clk); #1;
      in_valid_i   = 1'b1;
      in_sof_i     = (n == 0);
      in_eof_i     = with_eof && (n == fb.size() - 1);
      in_data_i    = fb[n];
      check_mode_i = chk;
      for (int g = 0; g < gap; g++) begin
        if (n == fb.size() - 1) break;
        @(posedge clk); #1;
        in_valid_i = 1'b0;
        in_sof_i   = 1'b1;
        in_eof_i   = 1'b1;
        in_data_i  = 8'hA5 ^ 8'(g);
      end
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    in_sof_i   = 1'b0;
    in_eof_i   = 1'b0;
    in_data_i  = 8'h5A;
  endtask

  task automatic send_frame(input bit chk, input int gap, input bit exp_pass, input string tag);
    exp_t e;
    e.crc  = model_crc();
    e.pass = chk && exp_pass;
    e.fail = chk && !exp_pass;
    e.tag  = tag;
    expq.push_back(e);
    drive_bytes(chk, gap, 1'b1);
    @(posedge clk); #1;
  endtask

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected done", 32'(done_o), 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(crc_o == e.crc, {e.tag, " crc"}, 32'(crc_o), 32'(e.crc));
        check(pass_o == e.pass && fail_o == e.fail, {e.tag, " pass/fail"},
              {30'd0, pass_o, fail_o}, {30'd0, e.pass, e.fail});
        last_crc = crc_o;
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expected=finish actual=timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(crc_o == 16'h0 && !done_o && !pass_o && !fail_o, "R1 reset state",
          {crc_o, 13'd0, done_o, pass_o, fail_o}, 32'd0);

    // R2/R3: known frame
    fb = '{8'h80, 8'h00, 8'h02, 8'h0F, 8'h0B};
    check(model_crc() == 16'hC029, "R2 model self", 32'(model_crc()), 32'hC029);
    send_frame(1'b0, 0, 1'b0, "R2 R7 known frame");
    @(negedge clk);
    check(crc_o == 16'hC029, "R2 known crc", 32'(crc_o), 32'hC029);
    check(crc_o[15:8] == 8'hC0 && crc_o[7:0] == 8'h29, "R3 byte order", 32'(crc_o), 32'hC029);

    // R10: hold over idle cycles with junk inputs
    repeat (5) begin
      @(posedge clk); #1;
      in_data_i = next_rand();
      in_eof_i  = 1'b1;
      in_sof_i  = 1'b1;
    end
    @(negedge clk);
    check(crc_o == 16'hC029 && !done_o, "R9 R10 idle hold", 32'(crc_o), 32'hC029);
    in_eof_i = 1'b0; in_sof_i = 1'b0;

    // R5: check mode with correct CRC appended, high byte first
    fb = '{8'h80, 8'h00, 8'h02, 8'h0F, 8'h0B, 8'hC0, 8'h29};
    send_frame(1'b1, 0, 1'b1, "R5 known check");
    @(negedge clk);
    check(crc_o == 16'h0000, "R5 residue zero", 32'(crc_o), 32'h0);

    // R6: corrupted CRC byte and corrupted data byte
    fb = '{8'h80, 8'h00, 8'h02, 8'h0F, 8'h0B, 8'hC0, 8'h28};
    send_frame(1'b1, 0, 1'b0, "R6 bad crc byte");
    fb = '{8'h80, 8'h01, 8'h02, 8'h0F, 8'h0B, 8'hC0, 8'h29};
    send_frame(1'b1, 1, 1'b0, "R6 bad data byte");

    // Preset visibility: all zero and all one frames
    fb = '{8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(1'b0, 0, 1'b0, "R2 zeros");
    fb = '{8'hFF, 8'hFF, 8'hFF};
    send_frame(1'b0, 0, 1'b0, "R2 ones");

    // R11: single byte frame
    fb = '{8'h3C};
    send_frame(1'b0, 0, 1'b0, "R11 one byte");

    // R8: restart mid frame (no eof on the first part)
    fb = '{8'h11, 8'h22, 8'h33};
    drive_bytes(1'b0, 0, 1'b0);
    fb = '{8'h44, 8'h55};
    send_frame(1'b0, 0, 1'b0, "R8 restart");

    // Pseudo-random frames, back to back vs with gaps, then checked (R9, R5)
    for (int t = 0; t < 8; t++) begin
      int len;
      len = 2 + t * 3;
      fb.delete();
      for (int i = 0; i < len; i++) fb.push_back(next_rand());
      send_frame(1'b0, 0, 1'b0, "R2 random tight");
      c = model_crc();
      send_frame(1'b0, 1 + (t % 3), 1'b0, "R9 random gapped");
      fb.push_back(c[15:8]);
      fb.push_back(c[7:0]);
      send_frame(1'b1, t % 2, 1'b1, "R5 random check");
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R4 all results seen", 32'(expq.size()), 32'd0);
    check(crc_o == last_crc, "R10 final hold", 32'(crc_o), 32'(last_crc));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule